// File: doc/BRIEF.md
# DMA Line-Chunking Request Issuer

This block takes DMA commands and turns each one into a series of memory requests. A command carries a read/write flag, a start address, a byte length, a completion tag and a per-transfer completion delay. The block cuts the byte range into pieces that never cross a 64-byte line. The first piece runs from the start address to the next line boundary. Each middle piece is one full line, and the last piece holds what remains. Every piece is stored in a 16-entry transmit queue and offered on a request channel.

The request channel is offer/accept. If an offer is refused, the head request is withdrawn and held until a retry pulse comes in. After each accepted request there is one idle cycle before the next offer. Each piece carries the index of the transfer slot it belongs to, and up to four transfers can be in flight at once. Responses name the slot and the number of bytes returned. When a slot has received every byte of its transfer, it waits out the transfer's delay and then pulses its completion tag. A count of requests that were queued but have not yet been answered drives a drained flag and a drain-done pulse.

Top module: `dma_line_issuer`

## Requirements
- R1: A command with address A and length L (L ≥ 1) produces requests in ascending address order. The first request starts at A and ends at the next multiple of 64 or at A+L, whichever comes first. Each later request starts on a multiple of 64 and is 64 bytes long, except the last, which holds the remainder. No request crosses a 64-byte line, and `req_size` gives the byte count (1 to 64).
- R2: Each request carries `req_offset`, the distance in bytes from the transfer's start address to the request's address. It also carries the command's write flag on `req_write` and the transfer slot index on `req_id`.
- R3: `cmd_ready` is low in any of these cases: `cmd_len` is 0; the free queue entries are fewer than ceil(((A mod 64) + L) / 64); no transfer slot is free; or the previous command is still being split. A command is accepted when `cmd_valid` and `cmd_ready` are both high at a clock edge. Its first request is offered two cycles after that edge.
- R4: If `req_valid` is high and `req_ready` is low at an edge, `req_valid` is low from the next cycle on. It stays low until `req_retry` is sampled high. The same head request (same address) is offered in the cycle after the retry is sampled.
- R5: After each accepted request, `req_valid` is low for exactly one cycle before the next queued request is offered. `req_retry` has no effect while no refusal is pending.
- R6: `drained` is high exactly when every request queued so far has received its response. `drain_done` pulses for one cycle, in the cycle after the edge where the outstanding count drops to zero.
- R7: `done_valid` pulses with the command's tag on `done_tag` once the response bytes credited to the transfer add up to its length. The pulse comes 2 + `cmd_delay` cycles after the cycle carrying the final response. Partial responses produce no pulse.
- R8: Up to four transfers are in flight at once, and a new command takes the lowest free slot index. Responses may arrive in any order across slots and within a slot. Each response is credited to the slot named by `rsp_id`.
- R9: After reset, `req_valid`, `done_valid` and `drain_done` are low, `drained` is high, and `cmd_ready` is high for a nonzero-length command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be accepted |
| cmd_write | input | 1 | 1 = write transfer, 0 = read |
| cmd_addr | input | 32 | Start byte address |
| cmd_len | input | 16 | Length in bytes |
| cmd_tag | input | 8 | Tag returned on completion |
| cmd_delay | input | 8 | Extra cycles before completion pulse |
| req_valid | output | 1 | Request offered |
| req_ready | input | 1 | Request accepted this cycle |
| req_write | output | 1 | Request write flag |
| req_addr | output | 32 | Request byte address |
| req_size | output | 7 | Request byte count (1 to 64) |
| req_offset | output | 16 | Byte offset within the transfer |
| req_id | output | 2 | Transfer slot index |
| req_retry | input | 1 | Retry after a refused offer |
| rsp_valid | input | 1 | Response arrives |
| rsp_id | input | 2 | Slot the response belongs to |
| rsp_bytes | input | 7 | Bytes carried by the response |
| done_valid | output | 1 | Transfer complete pulse |
| done_tag | output | 8 | Tag of the completed transfer |
| drained | output | 1 | No request awaiting response |
| drain_done | output | 1 | Outstanding count just reached zero |

## Verification
Every result has a fixed cycle distance from the stimulus that causes it. The first request appears two cycles after the command is accepted, and accepted requests are spaced two cycles apart. A re-offer follows the cycle in which the retry is sampled. The drain flags change one cycle after the final response, and the completion pulse comes 2 + delay cycles after it. A monitor samples the ports shortly after every falling clock edge and stamps each request, response, completion and drain pulse with its cycle number. The directed scenarios then compare those stamps against these exact offsets rather than waiting loosely. Refusal and queue-full cases are held for several cycles so that a missing stall shows up at the ports.

// File: rtl/dma_line_issuer.sv
module dma_line_issuer #(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 16,
  parameter int LINE_BYTES = 64,
  parameter int QDEPTH     = 16,
  parameter int NXFER      = 4,
  parameter int TAG_W      = 8,
  parameter int DLY_W      = 8,
  localparam int SZ_W      = $clog2(LINE_BYTES) + 1,
  localparam int ID_W      = (NXFER > 1) ? $clog2(NXFER) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_write,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [LEN_W-1:0]  cmd_len,
  input  logic [TAG_W-1:0]  cmd_tag,
  input  logic [DLY_W-1:0]  cmd_delay,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_write,
  output logic [ADDR_W-1:0] req_addr,
  output logic [SZ_W-1:0]   req_size,
  output logic [LEN_W-1:0]  req_offset,
  output logic [ID_W-1:0]   req_id,
  input  logic              req_retry,
  input  logic              rsp_valid,
  input  logic [ID_W-1:0]   rsp_id,
  input  logic [SZ_W-1:0]   rsp_bytes,
  output logic              done_valid,
  output logic [TAG_W-1:0]  done_tag,
  output logic              drained,
  output logic              drain_done
);
  localparam int LINE_W = $clog2(LINE_BYTES);
  localparam int QP_W   = (QDEPTH > 1) ? $clog2(QDEPTH) : 1;
  localparam int QC_W   = $clog2(QDEPTH + 1);
  localparam int OUT_W  = $clog2(NXFER * QDEPTH + 1);
  localparam int NEED_W = LEN_W + 2;

  // transmit queue
  logic              q_wr   [QDEPTH];
  logic [ADDR_W-1:0] q_addr [QDEPTH];
  logic [SZ_W-1:0]   q_size [QDEPTH];
  logic [LEN_W-1:0]  q_off  [QDEPTH];
  logic [ID_W-1:0]   q_id   [QDEPTH];
  logic [QP_W-1:0]   wp, rp;
  logic [QC_W-1:0]   q_cnt;

  // line splitter
  logic              gen_on, gen_wr;
  logic [ADDR_W-1:0] gen_addr;
  logic [LEN_W-1:0]  gen_rem, gen_off;
  logic [ID_W-1:0]   gen_id;
  logic [SZ_W-1:0]   room, gen_sz;

  // issue state
  logic wait_retry, gap;
  logic [OUT_W-1:0] outst, outst_n;

  // transfer slots
  logic              s_busy  [NXFER];
  logic              s_fin   [NXFER];
  logic [TAG_W-1:0]  s_tag   [NXFER];
  logic [LEN_W-1:0]  s_total [NXFER];
  logic [LEN_W-1:0]  s_got   [NXFER];
  logic [DLY_W-1:0]  s_tmr   [NXFER];

  logic              free_any, done_any;
  logic [ID_W-1:0]   free_idx, done_idx;
  logic [NEED_W-1:0] need, q_free;
  logic              accept, push, pop;

  assign need   = (NEED_W'(cmd_len) + NEED_W'(cmd_addr[LINE_W-1:0]) + NEED_W'(LINE_BYTES - 1)) >> LINE_W;
  assign q_free = NEED_W'(QDEPTH) - NEED_W'(q_cnt);

  assign cmd_ready = !gen_on && free_any && (cmd_len != '0) && (need <= q_free);
  assign accept    = cmd_valid && cmd_ready;
  assign push      = gen_on;

  assign req_valid  = (q_cnt != '0) && !wait_retry && !gap;
  assign req_write  = q_wr[rp];
  assign req_addr   = q_addr[rp];
  assign req_size   = q_size[rp];
  assign req_offset = q_off[rp];
  assign req_id     = q_id[rp];
  assign pop        = req_valid && req_ready;

  assign room   = SZ_W'(LINE_BYTES) - SZ_W'(gen_addr[LINE_W-1:0]);
  assign gen_sz = (LEN_W'(room) < gen_rem) ? room : SZ_W'(gen_rem);

  assign outst_n = outst + OUT_W'(push) - OUT_W'(rsp_valid);
  assign drained = (outst == '0);

  always_comb begin
    free_any = 1'b0;
    free_idx = '0;
    done_any = 1'b0;
    done_idx = '0;
    for (int i = NXFER - 1; i >= 0; i--) begin
      if (!s_busy[i]) begin
        free_any = 1'b1;
        free_idx = ID_W'(i);
      end
      if (s_busy[i] && s_fin[i] && s_tmr[i] == '0) begin
        done_any = 1'b1;
        done_idx = ID_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gen_on   <= 1'b0;
      gen_wr   <= 1'b0;
      gen_addr <= '0;
      gen_rem  <= '0;
      gen_off  <= '0;
      gen_id   <= '0;
    end else if (accept) begin
      gen_on   <= 1'b1;
      gen_wr   <= cmd_write;
      gen_addr <= cmd_addr;
      gen_rem  <= cmd_len;
      gen_off  <= '0;
      gen_id   <= free_idx;
    end else if (gen_on) begin
      gen_addr <= gen_addr + ADDR_W'(gen_sz);
      gen_rem  <= gen_rem - LEN_W'(gen_sz);
      gen_off  <= gen_off + LEN_W'(gen_sz);
      if (gen_rem == LEN_W'(gen_sz)) gen_on <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      q_wr[wp]   <= gen_wr;
      q_addr[wp] <= gen_addr;
      q_size[wp] <= gen_sz;
      q_off[wp]  <= gen_off;
      q_id[wp]   <= gen_id;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      q_cnt <= '0;
    end else begin
      if (push) wp <= (wp == QP_W'(QDEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == QP_W'(QDEPTH - 1)) ? '0 : rp + 1'b1;
      q_cnt <= q_cnt + QC_W'(push) - QC_W'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wait_retry <= 1'b0;
      gap        <= 1'b0;
      outst      <= '0;
      drain_done <= 1'b0;
    end else begin
      gap <= pop;
      if (req_valid && !req_ready) wait_retry <= 1'b1;
      else if (req_retry)          wait_retry <= 1'b0;
      outst      <= outst_n;
      drain_done <= (outst != '0) && (outst_n == '0);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_valid <= 1'b0;
      done_tag   <= '0;
      for (int i = 0; i < NXFER; i++) begin
        s_busy[i]  <= 1'b0;
        s_fin[i]   <= 1'b0;
        s_tag[i]   <= '0;
        s_total[i] <= '0;
        s_got[i]   <= '0;
        s_tmr[i]   <= '0;
      end
    end else begin
      done_valid <= done_any;
      done_tag   <= s_tag[done_idx];
      for (int i = 0; i < NXFER; i++) begin
        if (accept && free_idx == ID_W'(i)) begin
          s_busy[i]  <= 1'b1;
          s_fin[i]   <= 1'b0;
          s_tag[i]   <= cmd_tag;
          s_total[i] <= cmd_len;
          s_got[i]   <= '0;
          s_tmr[i]   <= cmd_delay;
        end else begin
          if (rsp_valid && rsp_id == ID_W'(i) && s_busy[i] && !s_fin[i]) begin
            s_got[i] <= s_got[i] + LEN_W'(rsp_bytes);
            if (({1'b0, s_got[i]} + (LEN_W + 1)'(rsp_bytes)) == {1'b0, s_total[i]})
              s_fin[i] <= 1'b1;
          end
          if (s_busy[i] && s_fin[i]) begin
            if (s_tmr[i] != '0) s_tmr[i] <= s_tmr[i] - 1'b1;
            else if (done_idx == ID_W'(i)) begin
              s_busy[i] <= 1'b0;
              s_fin[i]  <= 1'b0;
            end
          end
        end
      end
    end
  end

  // R1: every offered request stays inside one line
  a_r1_in_line: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_size != '0) &&
      ((SZ_W + 1)'(req_addr[LINE_W-1:0]) + (SZ_W + 1)'(req_size) <= (SZ_W + 1)'(LINE_BYTES)));

  // R3: the splitter never pushes into a full queue
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (q_cnt < QC_W'(QDEPTH)));

  // R4: a refused offer is withdrawn and its head is kept
  a_r4_refuse_withdraw: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> !req_valid);
  a_r4_head_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> $stable(req_addr));

  // R5: one idle cycle after every acceptance
  a_r5_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_valid);

  // R6: drain pulse only when fully drained
  a_r6_drain_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    drain_done |-> drained);

  // R8: responses only for a live slot
  a_r8_rsp_owner: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> s_busy[rsp_id] && !drained);
endmodule

// File: tb/sim_dma_line_issuer.sv
module sim_dma_line_issuer;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n;
  logic        cmd_valid, cmd_ready, cmd_write;
  logic [31:0] cmd_addr;
  logic [15:0] cmd_len;
  logic [7:0]  cmd_tag, cmd_delay;
  logic        req_valid, req_ready, req_write, req_retry;
  logic [31:0] req_addr;
  logic [6:0]  req_size;
  logic [15:0] req_offset;
  logic [1:0]  req_id;
  logic        rsp_valid;
  logic [1:0]  rsp_id;
  logic [6:0]  rsp_bytes;
  logic        done_valid;
  logic [7:0]  done_tag;
  logic        drained, drain_done;

  dma_line_issuer u0 (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_tag(cmd_tag), .cmd_delay(cmd_delay),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_offset(req_offset), .req_id(req_id),
    .req_retry(req_retry),
    .rsp_valid(rsp_valid), .rsp_id(rsp_id), .rsp_bytes(rsp_bytes),
    .done_valid(done_valid), .done_tag(done_tag),
    .drained(drained), .drain_done(drain_done)
  );

  int nchk = 0, nfail = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // port monitor, sampled 2 ns after each falling edge
  int          ln = 0, dn = 0, dd_n = 0, dd_cyc = 0, acc_cyc = 0, last_rsp = 0;
  logic [31:0] l_addr [64];
  int          l_size [64], l_off [64], l_id [64], l_wr [64], l_cyc [64];
  int          d_tag [64], d_cyc [64];
  int          rsp_cyc [4];

  always @(negedge clk) begin
    #2;
    if (req_valid && req_ready) begin
      if (ln < 64) begin
        l_addr[ln] = req_addr; l_size[ln] = req_size; l_off[ln] = req_offset;
        l_id[ln] = req_id; l_wr[ln] = req_write; l_cyc[ln] = cyc;
      end
      ln++;
    end
    if (cmd_valid && cmd_ready) acc_cyc = cyc;
    if (rsp_valid) begin rsp_cyc[rsp_id] = cyc; last_rsp = cyc; end
    if (done_valid) begin
      if (dn < 64) begin d_tag[dn] = done_tag; d_cyc[dn] = cyc; end
      dn++;
    end
    if (drain_done) begin dd_n++; dd_cyc = cyc; end
  end

  task automatic chk(input bit ok, input string r, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: got %0d expected %0d", r, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_cmd(input bit w, input logic [31:0] a, input int len, input int tag, input int dly);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_write = w; cmd_addr = a; cmd_len = 16'(len);
    cmd_tag = 8'(tag); cmd_delay = 8'(dly);
    #1;
    while (!cmd_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic rsp_send(input int id, input int bytes);
    @(negedge clk);
    rsp_valid = 1'b1; rsp_id = 2'(id); rsp_bytes = 7'(bytes);
    @(negedge clk);
    rsp_valid = 1'b0;
  endtask

  task automatic wait_log(input int n);
    for (int k = 0; k < 300 && ln < n; k++) @(negedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk); #1;
    chk(req_valid == 1'b0, "R9 req_valid", req_valid, 0);
    chk(cmd_ready == 1'b1, "R9 cmd_ready", cmd_ready, 1);
    chk(drained == 1'b1, "R9 drained", drained, 1);
    chk(done_valid == 1'b0 && drain_done == 1'b0, "R9 pulses", done_valid, 0);
  endtask

  task automatic t_split;
    logic [31:0] ea [4] = '{32'h1030, 32'h1040, 32'h1080, 32'h10C0};
    int es [4] = '{16, 64, 64, 56};
    int eo [4] = '{0, 16, 80, 144};
    int l0 = ln, d0 = dn, dd0 = dd_n, id;
    req_ready = 1'b1;
    send_cmd(1'b1, 32'h1030, 200, 8'h21, 0);
    wait_log(l0 + 4);
    idle(2);
    chk(ln == l0 + 4, "R1 chunk count", ln - l0, 4);
    id = l_id[l0];
    for (int i = 0; i < 4; i++) begin
      chk(l_addr[l0+i] == ea[i], "R1 chunk addr", l_addr[l0+i], ea[i]);
      chk(l_size[l0+i] == es[i], "R1 chunk size", l_size[l0+i], es[i]);
      chk(l_off[l0+i] == eo[i], "R2 chunk offset", l_off[l0+i], eo[i]);
      chk(l_wr[l0+i] == 1 && l_id[l0+i] == id, "R2 write flag and slot", l_wr[l0+i], 1);
      chk(l_cyc[l0+i] == acc_cyc + 2 + 2*i, "R5 issue cycle", l_cyc[l0+i], acc_cyc + 2 + 2*i);
    end
    chk(drained == 1'b0, "R6 draining while outstanding", drained, 0);
    rsp_send(id, 56);
    rsp_send(id, 16);
    rsp_send(id, 64);
    idle(6);
    chk(dn == d0, "R7 no completion on partial bytes", dn - d0, 0);
    chk(drained == 1'b0, "R6 still outstanding", drained, 0);
    rsp_send(id, 64);
    idle(4);
    chk(dn == d0 + 1 && d_tag[d0] == 8'h21, "R7 completion tag", d_tag[d0], 8'h21);
    chk(d_cyc[d0] == last_rsp + 2, "R7 completion cycle", d_cyc[d0], last_rsp + 2);
    chk(drained == 1'b1, "R6 drained after last response", drained, 1);
    chk(dd_n == dd0 + 1 && dd_cyc == last_rsp + 1, "R6 drain_done timing", dd_cyc, last_rsp + 1);
  endtask

  task automatic t_small;
    int l0 = ln, d0 = dn;
    req_ready = 1'b1;
    send_cmd(1'b0, 32'h203F, 1, 8'h30, 0);
    wait_log(l0 + 1);
    idle(3);
    chk(ln == l0 + 1 && l_addr[l0] == 32'h203F && l_size[l0] == 1, "R1 single byte at line end", l_size[l0], 1);
    chk(l_wr[l0] == 0 && l_off[l0] == 0, "R2 read flag", l_wr[l0], 0);
    rsp_send(l_id[l0], 1);
    send_cmd(1'b0, 32'h2000, 64, 8'h31, 2);
    wait_log(l0 + 2);
    idle(3);
    chk(ln == l0 + 2 && l_size[l0+1] == 64 && l_addr[l0+1] == 32'h2000, "R1 aligned full line", l_size[l0+1], 64);
    rsp_send(l_id[l0+1], 64);
    idle(8);
    chk(dn == d0 + 2 && d_tag[d0+1] == 8'h31, "R7 second tag", d_tag[d0+1], 8'h31);
    chk(d_cyc[d0+1] == last_rsp + 4, "R7 delay of 2", d_cyc[d0+1], last_rsp + 4);
  endtask

  task automatic t_retry;
    int l0 = ln, r, low_cnt = 0;
    req_ready = 1'b0;
    send_cmd(1'b0, 32'h3000, 64, 3, 0);
    @(negedge clk);
    chk(req_valid == 1'b1 && req_addr == 32'h3000, "R3 first offer two cycles after accept", req_valid, 1);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (req_valid) low_cnt++;
    end
    chk(low_cnt == 0, "R4 withdrawn until retry", low_cnt, 0);
    req_retry = 1'b1; req_ready = 1'b1; r = cyc;
    @(negedge clk);
    req_retry = 1'b0;
    idle(3);
    chk(ln == l0 + 1 && l_addr[l0] == 32'h3000, "R4 same head re-offered", l_addr[l0], 32'h3000);
    chk(l_cyc[l0] == r + 1, "R4 re-offer cycle", l_cyc[l0], r + 1);
    rsp_send(l_id[l0], 64);
    idle(4);
  endtask

  task automatic t_retry_idle;
    int l0 = ln;
    req_ready = 1'b1; req_retry = 1'b1;
    send_cmd(1'b1, 32'h5000, 128, 5, 0);
    wait_log(l0 + 2);
    idle(3);
    req_retry = 1'b0;
    chk(ln == l0 + 2, "R5 two chunks with retry held", ln - l0, 2);
    chk(l_cyc[l0+1] - l_cyc[l0] == 2, "R5 spacing kept with stray retry", l_cyc[l0+1] - l_cyc[l0], 2);
    rsp_send(l_id[l0], 64);
    rsp_send(l_id[l0], 64);
    idle(4);
  endtask

  task automatic t_full;
    int l0, d0 = dn;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_addr = 32'h4000; cmd_len = 16'd0; #1;
    chk(cmd_ready == 1'b0, "R3 zero length refused", cmd_ready, 0);
    cmd_addr = 32'h4001; cmd_len = 16'd1024; #1;
    chk(cmd_ready == 1'b0, "R3 seventeen chunks refused", cmd_ready, 0);
    cmd_len = 16'd1023; #1;
    chk(cmd_ready == 1'b1, "R3 sixteen chunks fit", cmd_ready, 1);
    req_ready = 1'b0;
    l0 = ln;
    send_cmd(1'b1, 32'h4000, 1024, 4, 0);
    idle(22);
    cmd_addr = 32'h0; cmd_len = 16'd1; #1;
    chk(cmd_ready == 1'b0, "R3 full queue refuses command", cmd_ready, 0);
    chk(req_valid == 1'b0, "R4 held while refused", req_valid, 0);
    @(negedge clk);
    req_retry = 1'b1; req_ready = 1'b1;
    @(negedge clk);
    req_retry = 1'b0;
    wait_log(l0 + 16);
    idle(3);
    chk(ln == l0 + 16, "R1 sixteen line requests", ln - l0, 16);
    chk(l_addr[l0+15] == 32'h43C0 && l_off[l0+15] == 960, "R2 last chunk offset", l_off[l0+15], 960);
    for (int i = 0; i < 16; i++) rsp_send(l_id[l0], 64);
    idle(4);
    chk(dn == d0 + 1 && d_tag[d0] == 4, "R7 tag after sixteen responses", d_tag[d0], 4);
  endtask

  task automatic t_slots;
    int dly [4] = '{3, 0, 1, 5};
    int ord [4] = '{2, 0, 3, 1};
    int l0 = ln, d0 = dn, s;
    req_ready = 1'b1;
    for (int i = 0; i < 4; i++) send_cmd(1'b0, 32'h6000 + 32'(i) * 32'h100, 8, 10 + i, dly[i]);
    wait_log(l0 + 4);
    idle(5);
    for (int i = 0; i < 4; i++)
      chk(l_id[l0+i] == i, "R8 lowest free slot", l_id[l0+i], i);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_addr = 32'h7000; cmd_len = 16'd8; #1;
    chk(cmd_ready == 1'b0, "R3 no free slot", cmd_ready, 0);
    @(negedge clk);
    cmd_valid = 1'b0;
    for (int i = 0; i < 4; i++) rsp_send(ord[i], 8);
    idle(12);
    chk(dn == d0 + 4, "R8 four completions", dn - d0, 4);
    for (int i = 0; i < 4; i++) begin
      s = d_tag[d0+i] - 10;
      if (s < 0 || s > 3) s = 0;
      chk(d_cyc[d0+i] == rsp_cyc[s] + 2 + dly[s], "R7 per-slot delay", d_cyc[d0+i], rsp_cyc[s] + 2 + dly[s]);
    end
    chk(drained == 1'b1, "R6 drained at end", drained, 1);
  endtask

  initial begin
    #2000000;
    nchk++; nfail++;
    $display("FAIL watchdog: got 1 expected 0");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_write = 1'b0; cmd_addr = '0; cmd_len = 16'd8;
    cmd_tag = '0; cmd_delay = '0; req_ready = 1'b0; req_retry = 1'b0;
    rsp_valid = 1'b0; rsp_id = '0; rsp_bytes = '0;
    idle(3);
    rst_n = 1'b1;
    t_reset();
    t_split();
    t_small();
    t_retry();
    t_retry_idle();
    t_full();
    t_slots();
    idle(2);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule